// File: doc/BRIEF.md
# Level-Based Bus Access Gate

This block sits on the path from a user processor bus to the memory-mapped system peripherals. It looks at every request, decides whether to let it through, and either hands it on unchanged to the peripheral side or finishes it at once with an error. Two things decide the outcome. The first is a single communication-enable bit. A boot sequencer sets it once its secure start-up checks have passed, and only a reset clears it again. The second is a permission table that holds one read bit and one write bit for every pairing of security level and address region.

The boot sequencer presents the user's security level on `lvl_in` and pulses `en_set`. The gate stores both the level and the enable in that same cycle. From then on, the stored level picks the row of the permission table. The top address bits pick the region, and the direction of the access picks the read bit or the write bit. Refused requests are counted in a saturating counter that can be read on `viol_count`.

Top module: `lbg_access_gate`

## Requirements
- R1: After reset the enable is clear, the stored level is 0 and `viol_count` is 0.
- R2: While the enable is clear, no request is forwarded (`p_valid` stays 0). Every valid request is refused.
- R3: A cycle with `en_set` high while the enable is clear sets the enable and stores `lvl_in`. The enable then stays set until reset, and further `en_set` pulses have no effect.
- R4: The region is the top `REGION_BITS` address bits. The permission bit index is `level*2^REGION_BITS + region`: reads use `PERM_RD` and writes use `PERM_WR`. The defaults are `PERM_RD=32'hFF7F1F07` and `PERM_WR=32'hF0300C03`.
- R5: A permitted request is forwarded in the same cycle. It raises `p_valid` and `u_grant`, passes `p_addr`, `p_write` and `p_wdata` through unchanged, and keeps `u_err` at 0.
- R6: A refused request completes in the cycle it is presented. It raises `u_ready` and `u_err`, and `p_valid` stays 0.
- R7: `viol_count` rises by one at the clock edge after each cycle holding a refused request. It saturates at 2^`CNT_W`-1 and does not change in any other cycle.
- R8: Changes on `lvl_in` after the enable is set do not change the policy in use.
- R9: A permitted request waits while `p_ready` is low. During that time `u_ready` stays low and `u_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the enable, the level and the counter |
| en_set | input | 1 | Pulse from the boot sequencer that opens the gate |
| lvl_in | input | $clog2(LEVELS) | Security level, stored together with the enable |
| u_valid | input | 1 | A request is present on the user side |
| u_ready | output | 1 | The request completes this cycle |
| u_write | input | 1 | 1 = write, 0 = read |
| u_addr | input | ADDR_W | Request address |
| u_wdata | input | DATA_W | Write data |
| u_grant | output | 1 | The request is permitted and forwarded |
| u_err | output | 1 | The request is refused (error response) |
| p_valid | output | 1 | A forwarded request is present on the peripheral side |
| p_ready | input | 1 | The peripheral side accepts the request |
| p_write | output | 1 | Forwarded direction |
| p_addr | output | ADDR_W | Forwarded address |
| p_wdata | output | DATA_W | Forwarded write data |
| viol_count | output | CNT_W | Saturating count of refused requests |

## Verification
The bench builds the gate with `ADDR_W=8`, `DATA_W=16`, `CNT_W=4` and the default four levels, eight regions and permission masks. With an 8-bit address, every region boundary can be written as a short literal. Every level is visited through a reset followed by a boot with that level, so one table covers both allowed and refused reads and writes on each row. The 4-bit counter reaches its ceiling of 15 after a handful of refused requests, which brings saturation within a short directed test.

// File: rtl/lbg_pkg.sv
package lbg_pkg;
    typedef enum logic {
        ACC_RD = 1'b0,
        ACC_WR = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/lbg_perm_lookup.sv
module lbg_perm_lookup #(
    parameter int LEVELS      = 4,
    parameter int REGION_BITS = 3,
    parameter logic [LEVELS*(2**REGION_BITS)-1:0] PERM_RD = '0,
    parameter logic [LEVELS*(2**REGION_BITS)-1:0] PERM_WR = '0
) (
    input  logic [$clog2(LEVELS)-1:0] lvl,
    input  logic [REGION_BITS-1:0]    region,
    input  lbg_pkg::acc_kind_e        kind,
    output logic                      allow
);
    localparam int REGIONS = 2**REGION_BITS;

    logic [LEVELS-1:0][REGIONS-1:0] row_rd;
    logic [LEVELS-1:0][REGIONS-1:0] row_wr;

    for (genvar l = 0; l < LEVELS; l++) begin : g_row
        assign row_rd[l] = PERM_RD[l*REGIONS +: REGIONS];
        assign row_wr[l] = PERM_WR[l*REGIONS +: REGIONS];
    end

    always_comb begin
        allow = 1'b0;
        if (int'(lvl) < LEVELS) begin
            allow = (kind == lbg_pkg::ACC_WR) ? row_wr[lvl][region] : row_rd[lvl][region];
        end
    end
endmodule

// File: rtl/lbg_sat_counter.sv
module lbg_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R7: a refused request below the ceiling adds exactly one
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R7: no refused request, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
    // R7: the ceiling is sticky
    a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP));
endmodule

// File: rtl/lbg_access_gate.sv
module lbg_access_gate #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int LEVELS      = 4,
    parameter int REGION_BITS = 3,
    parameter int CNT_W       = 8,
    parameter logic [LEVELS*(2**REGION_BITS)-1:0] PERM_RD = 32'hFF7F1F07,
    parameter logic [LEVELS*(2**REGION_BITS)-1:0] PERM_WR = 32'hF0300C03
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_set,
    input  logic [$clog2(LEVELS)-1:0] lvl_in,
    input  logic                      u_valid,
    output logic                      u_ready,
    input  logic                      u_write,
    input  logic [ADDR_W-1:0]         u_addr,
    input  logic [DATA_W-1:0]         u_wdata,
    output logic                      u_grant,
    output logic                      u_err,
    output logic                      p_valid,
    input  logic                      p_ready,
    output logic                      p_write,
    output logic [ADDR_W-1:0]         p_addr,
    output logic [DATA_W-1:0]         p_wdata,
    output logic [CNT_W-1:0]          viol_count
);
    import lbg_pkg::*;

    localparam int LVL_W = $clog2(LEVELS);

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic [REGION_BITS-1:0] region;
    acc_kind_e              kind;
    logic                   allow;
    logic                   pass;

    assign region = u_addr[ADDR_W-1 -: REGION_BITS];
    assign kind   = u_write ? ACC_WR : ACC_RD;

    lbg_perm_lookup #(
        .LEVELS      (LEVELS),
        .REGION_BITS (REGION_BITS),
        .PERM_RD     (PERM_RD),
        .PERM_WR     (PERM_WR)
    ) u_lookup (
        .lvl    (st_q.lvl),
        .region (region),
        .kind   (kind),
        .allow  (allow)
    );

    always_comb begin
        st_d = st_q;
        if (en_set && !st_q.en) begin
            st_d.en  = 1'b1;
            st_d.lvl = lvl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pass    = st_q.en && allow;
    assign u_grant = u_valid && pass;
    assign u_err   = u_valid && !pass;
    assign u_ready = pass ? p_ready : 1'b1;
    assign p_valid = u_grant;
    assign p_write = u_write;
    assign p_addr  = u_addr;
    assign p_wdata = u_wdata;

    lbg_sat_counter #(.W(CNT_W)) u_viol (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (u_err),
        .count (viol_count)
    );

    // R3: once open, the gate stays open until reset
    a_r3_en_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> st_q.en);
    // R8: the stored level is frozen while the gate is open
    a_r8_lvl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> $stable(st_q.lvl));
    // R2: nothing is forwarded before the gate opens
    a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> !p_valid);
    // R6: a refused request completes at once and is not forwarded
    a_r6_deny_done: assert property (@(posedge clk) disable iff (!rst_n)
        u_err |-> (u_ready && !p_valid));
    // R5: forwarded fields match the request
    a_r5_fields: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (p_addr == u_addr && p_write == u_write && p_wdata == u_wdata));
    // R9: a waiting permitted request is held on the user side
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (u_grant && !p_ready) |-> (!u_ready && !u_err));
endmodule

// File: tb/tb_lbg_access_gate.sv
`timescale 1ns/1ps
module tb_lbg_access_gate;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_set = 1'b0;
    logic [1:0]    lvl_in = '0;
    logic          u_valid = 1'b0;
    logic          u_ready;
    logic          u_write = 1'b0;
    logic [AW-1:0] u_addr = '0;
    logic [DW-1:0] u_wdata = '0;
    logic          u_grant, u_err, p_valid;
    logic          p_ready = 1'b1;
    logic          p_write;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;
    logic [CW-1:0] viol_count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    lbg_access_gate #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .lvl_in(lvl_in),
        .u_valid(u_valid), .u_ready(u_ready), .u_write(u_write),
        .u_addr(u_addr), .u_wdata(u_wdata), .u_grant(u_grant), .u_err(u_err),
        .p_valid(p_valid), .p_ready(p_ready), .p_write(p_write),
        .p_addr(p_addr), .p_wdata(p_wdata), .viol_count(viol_count)
    );

    // {level[1:0], write, addr[7:0], expect_grant}, from the R4 default masks
    localparam logic [11:0] VEC [14] = '{
        {2'd0, 1'b0, 8'h40, 1'b1}, {2'd0, 1'b0, 8'h60, 1'b0},
        {2'd0, 1'b1, 8'h20, 1'b1}, {2'd0, 1'b1, 8'h40, 1'b0},
        {2'd1, 1'b0, 8'h80, 1'b1}, {2'd1, 1'b0, 8'hA0, 1'b0},
        {2'd1, 1'b1, 8'h7F, 1'b1}, {2'd1, 1'b1, 8'h00, 1'b0},
        {2'd2, 1'b0, 8'hC5, 1'b1}, {2'd2, 1'b1, 8'hBF, 1'b1},
        {2'd2, 1'b1, 8'hC0, 1'b0}, {2'd3, 1'b0, 8'hE0, 1'b1},
        {2'd3, 1'b1, 8'hFF, 1'b1}, {2'd3, 1'b1, 8'h60, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; u_valid = 1'b0; en_set = 1'b0; p_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    task automatic boot(input logic [1:0] lvl);
        @(negedge clk);
        en_set = 1'b1; lvl_in = lvl;
        @(negedge clk);
        en_set = 1'b0;
    endtask

    task automatic drive(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        u_valid = 1'b1; u_write = wr; u_addr = a; u_wdata = d;
        #1;
    endtask

    task automatic bump();
        if (exp_cnt < 15) exp_cnt++;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk(viol_count == 0, "R1 counter after reset", viol_count, 0);
        // R2: request before the gate opens
        drive(1'b0, 8'h00, '0);
        chk(u_err && u_ready, "R2 refused before enable", u_err, 1);
        chk(!p_valid, "R2 no forward before enable", p_valid, 0);
        @(posedge clk); #1; bump();
        chk(viol_count == exp_cnt, "R7 count after refusal", viol_count, exp_cnt);
        @(negedge clk); u_valid = 1'b0;

        // Table walk over all levels (R4, R5, R6, R7)
        begin
            int cur = -1;
            for (int i = 0; i < 14; i++) begin
                logic [1:0] lv; logic wr; logic [7:0] a; logic g;
                {lv, wr, a, g} = VEC[i];
                if (int'(lv) != cur) begin
                    do_reset();
                    boot(lv);
                    cur = int'(lv);
                end
                drive(wr, a, 16'(i * 257));
                chk(u_grant == g && p_valid == g, "R4 permission decision", u_grant, g);
                chk(u_err == !g && u_ready, "R6 error and completion", u_err, !g);
                if (g) chk(p_addr == a && p_write == wr, "R5 forwarded fields", p_addr, a);
                @(posedge clk); #1;
                if (!g) bump();
                chk(viol_count == exp_cnt, "R7 counter tracks refusals", viol_count, exp_cnt);
                @(negedge clk); u_valid = 1'b0;
            end
        end

        // R3 / R8: second en_set with a new level is ignored
        do_reset();
        boot(2'd0);
        boot(2'd3);
        lvl_in = 2'd3;
        drive(1'b0, 8'hE0, '0);
        chk(u_err && !p_valid, "R8 level frozen after enable", u_err, 1);
        drive(1'b1, 8'h20, '0);
        chk(u_grant, "R3 enable still set", u_grant, 1);

        // R9: stall on a permitted request
        @(negedge clk); u_valid = 1'b0; exp_cnt = 1;
        @(negedge clk); #1;
        drive(1'b0, 8'h00, '0);
        p_ready = 1'b0; #1;
        chk(!u_ready && u_grant && !u_err, "R9 stall holds request", u_ready, 0);
        @(posedge clk); #1;
        chk(viol_count == exp_cnt, "R9 stall not counted", viol_count, exp_cnt);
        @(negedge clk); p_ready = 1'b1; #1;
        chk(u_ready, "R9 ready follows peripheral", u_ready, 1);

        // R5: write data forwarded unchanged
        drive(1'b1, 8'h3C, 16'hA5C3);
        chk(p_wdata == 16'hA5C3, "R5 write data forwarded", p_wdata, 16'hA5C3);

        // R7: idle cycles leave the counter alone
        @(negedge clk); u_valid = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(viol_count == exp_cnt, "R7 idle no change", viol_count, exp_cnt);

        // R7: saturation with a locked gate
        do_reset();
        @(negedge clk);
        u_valid = 1'b1; u_write = 1'b0; u_addr = 8'h00;
        repeat (20) @(posedge clk);
        #1;
        chk(viol_count == 15, "R7 saturates at ceiling", viol_count, 15);
        @(negedge clk); u_valid = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule